// File: doc/BRIEF.md
# Protection Event Snapshot Logger

This block keeps a traceable record of every protection trip in a motor-drive power stage. Each detection path (threshold comparator, desaturation detector, gate-driver fault latch, run-time self-test) raises a one-cycle strobe together with a fault code. On that clock edge the block captures the code, a one-hot mark of the path that fired, a timestamp from a free-running cycle counter and a full snapshot of the live system values: phase current, bus voltage, temperature, position, feedback validity flags and the drive enable state. All of these are taken in the same cycle, so the record shows the state at the trip.

Captured records wait in one staging slot per path. A fixed-priority drain writes them one per cycle into a small circular buffer, so trips that fire together become separate records in a known order. After every reset release, a nonzero reset-cause vector (watchdog, brown-out, lockup) is logged once as its own record ahead of everything else. A host reads the oldest record from flat output fields and pops it with a read strobe. A full buffer drops its oldest record to make room and raises a sticky overflow flag.

Top module: `prot_event_logger`

## Requirements
- R1: After reset the record count is 0, the overflow flag is 0, and all read fields are 0. Whenever the buffer is empty the read code is 0, the "no event" code.
- R2: The 4-bit code field holds the code given with the strobe. Code values: 0 none, 1 desaturation, 2 overcurrent, 3 undervoltage, 4 over-temperature, 5 feedback invalid, 6 torque-off active, 7 reset cause.
- R3: For path records the source field is one-hot. Bit 0 is the comparator, bit 1 desaturation, bit 2 driver latch, bit 3 self-test.
- R4: The timestamp counter is 0 in the first cycle after reset release and adds 1 every cycle after that. A record carries the counter value of the cycle in which its strobe was sampled.
- R5: Every snapshot field is taken at the edge that samples the strobe. Later changes to the snapshot inputs leave the record unchanged.
- R6: Strobes sampled on the same edge produce one record each. These records share one timestamp and one snapshot and are stored in ascending path index.
- R7: In the first cycle after reset release, a nonzero reset cause (bit 0 watchdog, bit 1 brown-out, bit 2 lockup) produces one record. That record has code 7, the cause in source bits 2:0, and priority over path strobes of the same cycle. A zero cause produces no record.
- R8: A lone strobe sampled at edge E raises the count at edge E+1, not earlier.
- R9: A write into a full buffer with no read in the same cycle drops the oldest record. The count stays at the depth and the overflow flag is set.
- R10: A read strobe at an edge with a nonzero count removes the oldest record, and the next oldest appears on the read fields. A read strobe on an empty buffer changes nothing.
- R11: A strobe from a path whose previous record is still staged and not drained that cycle is discarded and sets the overflow flag.
- R12: Once set, the overflow flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | NSRC | Per-path trip strobes |
| trig_code_i | input | NSRC*4 | Fault code per path, path i at bits 4i+3:4i |
| rcause_i | input | 3 | Reset cause vector |
| snap_cur_i | input | CUR_W | Live phase current |
| snap_vbus_i | input | VBUS_W | Live bus voltage |
| snap_temp_i | input | TEMP_W | Live temperature |
| snap_pos_i | input | POS_W | Live position |
| snap_valid_i | input | VAL_W | Live validity flags |
| snap_en_i | input | 1 | Live drive enable |
| rd_i | input | 1 | Pop the oldest record |
| rd_code_o | output | 4 | Oldest record: fault code |
| rd_src_o | output | NSRC | Oldest record: source field |
| rd_ts_o | output | TS_W | Oldest record: timestamp |
| rd_cur_o | output | CUR_W | Oldest record: current |
| rd_vbus_o | output | VBUS_W | Oldest record: bus voltage |
| rd_temp_o | output | TEMP_W | Oldest record: temperature |
| rd_pos_o | output | POS_W | Oldest record: position |
| rd_valid_o | output | VAL_W | Oldest record: validity flags |
| rd_en_o | output | 1 | Oldest record: enable state |
| count_o | output | $clog2(DEPTH+1) | Stored record count |
| overflow_o | output | 1 | Sticky loss flag |

## Verification
The bench builds the block with DEPTH set to 4 and four paths. With that setting, one burst of all four strobes fills the buffer exactly, and a single extra strobe forces an overwrite of the oldest record. A four-path burst followed by an immediate second strobe on the lowest-priority path puts that path in the busy-slot case. Snapshot and timestamp widths stay at their defaults, so the captured fields are compared at full width against values the bench derives from a per-vector seed.

// File: rtl/plog_pkg.sv
`timescale 1ns/1ps
package plog_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    FC_NONE      = 4'd0,
    FC_DESAT     = 4'd1,
    FC_OVERCUR   = 4'd2,
    FC_UNDERVOLT = 4'd3,
    FC_OVERTEMP  = 4'd4,
    FC_FBINVALID = 4'd5,
    FC_TORQUEOFF = 4'd6,
    FC_RESET     = 4'd7
  } fault_code_e;

  // circular pointer step
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned lim);
    return (p + 1 == lim) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/plog_timebase.sv
`timescale 1ns/1ps
module plog_timebase #(
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + TS_W'(1);
  end
  assign ts_o = cnt_q;

  AST_TS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ts_o == TS_W'($past(ts_o) + TS_W'(1)))); // R4
endmodule

// File: rtl/plog_stage.sv
`timescale 1ns/1ps
module plog_stage #(
  parameter int NSLOT = 5,
  parameter int ENT_W = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSLOT-1:0]       tv_i,
  input  logic [NSLOT*ENT_W-1:0] td_i,
  output logic                   wr_o,
  output logic [ENT_W-1:0]       wr_data_o,
  output logic                   drop_o
);
  logic [NSLOT-1:0] valid_q;
  logic [NSLOT-1:0] grant;
  logic [NSLOT-1:0] drop;
  logic [ENT_W-1:0] data_arr [NSLOT];

  // lowest slot index drains first
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int j = 0; j < NSLOT; j++) begin
      if (valid_q[j] && !found) begin
        grant[j] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    wr_data_o = '0;
    for (int j = 0; j < NSLOT; j++)
      if (grant[j]) wr_data_o = data_arr[j];
  end

  assign wr_o   = |grant;
  assign drop_o = |drop;

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    logic             v_q;
    logic [ENT_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (tv_i[j] && (!v_q || grant[j])) begin
        v_q <= 1'b1;
        d_q <= td_i[j*ENT_W +: ENT_W];
      end else if (grant[j]) begin
        v_q <= 1'b0;
      end
    end
    assign valid_q[j]  = v_q;
    assign data_arr[j] = d_q;
    assign drop[j]     = tv_i[j] & v_q & ~grant[j];

    AST_SLOT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tv_i[j] && !valid_q[j]) |=> valid_q[j]); // R6
  end
endmodule

// File: rtl/plog_ring.sv
`timescale 1ns/1ps
module plog_ring
  import plog_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ENT_W = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [ENT_W-1:0] wr_data_i,
  input  logic             rd_i,
  input  logic             drop_i,
  output logic [ENT_W-1:0] rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full, empty, do_pop, overwrite;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign do_pop    = rd_i & ~empty;
  assign overwrite = wr_i & full & ~do_pop;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[tail_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_i) tail_q <= PTR_W'(wrap_inc(32'(tail_q), DEPTH));
      if (do_pop || overwrite) head_q <= PTR_W'(wrap_inc(32'(head_q), DEPTH));
      if (wr_i && !do_pop && !full)  cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !wr_i)      cnt_q <= cnt_q - CNT_W'(1);
      if (overwrite || drop_i) ovf_q <= 1'b1;
    end
  end

  assign rd_data_o = empty ? '0 : mem[head_q];
  assign count_o   = cnt_q;
  assign ovf_o     = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R12
  AST_FULL_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full && !rd_i) |=> ovf_q); // R9
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full) |=> (cnt_q == CNT_W'(DEPTH))); // R9
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty && !wr_i) |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/prot_event_logger.sv
`timescale 1ns/1ps
module prot_event_logger
  import plog_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter int DEPTH  = 8,
  parameter int TS_W   = 16,
  parameter int CUR_W  = 16,
  parameter int VBUS_W = 12,
  parameter int TEMP_W = 10,
  parameter int POS_W  = 16,
  parameter int VAL_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSRC-1:0]        trig_i,
  input  logic [NSRC*CODE_W-1:0] trig_code_i,
  input  logic [2:0]             rcause_i,
  input  logic [CUR_W-1:0]       snap_cur_i,
  input  logic [VBUS_W-1:0]      snap_vbus_i,
  input  logic [TEMP_W-1:0]      snap_temp_i,
  input  logic [POS_W-1:0]       snap_pos_i,
  input  logic [VAL_W-1:0]       snap_valid_i,
  input  logic                   snap_en_i,
  input  logic                   rd_i,
  output logic [CODE_W-1:0]      rd_code_o,
  output logic [NSRC-1:0]        rd_src_o,
  output logic [TS_W-1:0]        rd_ts_o,
  output logic [CUR_W-1:0]       rd_cur_o,
  output logic [VBUS_W-1:0]      rd_vbus_o,
  output logic [TEMP_W-1:0]      rd_temp_o,
  output logic [POS_W-1:0]       rd_pos_o,
  output logic [VAL_W-1:0]       rd_valid_o,
  output logic                   rd_en_o,
  output logic [CNT_W-1:0]       count_o,
  output logic                   overflow_o
);
  // record layout, least significant first
  localparam int O_VAL  = 1;
  localparam int O_POS  = O_VAL + VAL_W;
  localparam int O_TEMP = O_POS + POS_W;
  localparam int O_VBUS = O_TEMP + TEMP_W;
  localparam int O_CUR  = O_VBUS + VBUS_W;
  localparam int SNAP_W = O_CUR + CUR_W;
  localparam int O_TS   = SNAP_W;
  localparam int O_SRC  = O_TS + TS_W;
  localparam int O_CODE = O_SRC + NSRC;
  localparam int ENT_W  = O_CODE + CODE_W;
  localparam int NSLOT  = NSRC + 1;

  logic [TS_W-1:0]        ts;
  logic [SNAP_W-1:0]      snap;
  logic                   boot_done_q;
  logic [NSLOT-1:0]       tv;
  logic [NSLOT*ENT_W-1:0] td;
  logic                   st_wr, st_drop;
  logic [ENT_W-1:0]       st_data, rd_entry;

  plog_timebase #(.TS_W(TS_W)) i_timebase (
    .clk_i(clk_i), .rst_ni(rst_ni), .ts_o(ts)
  );

  assign snap = {snap_cur_i, snap_vbus_i, snap_temp_i, snap_pos_i, snap_valid_i, snap_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_done_q <= 1'b0;
    else         boot_done_q <= 1'b1;
  end

  // slot 0 carries the reset-cause record, slots 1..NSRC the paths
  assign tv[0] = ~boot_done_q & (|rcause_i);
  assign td[0 +: ENT_W] = {FC_RESET, NSRC'(rcause_i), ts, snap};

  for (genvar i = 0; i < NSRC; i++) begin : g_path
    assign tv[i+1] = trig_i[i];
    assign td[(i+1)*ENT_W +: ENT_W] =
      {trig_code_i[i*CODE_W +: CODE_W], NSRC'(1) << i, ts, snap};
  end

  plog_stage #(.NSLOT(NSLOT), .ENT_W(ENT_W)) i_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .tv_i(tv), .td_i(td),
    .wr_o(st_wr), .wr_data_o(st_data), .drop_o(st_drop)
  );

  plog_ring #(.DEPTH(DEPTH), .ENT_W(ENT_W)) i_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(st_wr), .wr_data_i(st_data),
    .rd_i(rd_i), .drop_i(st_drop), .rd_data_o(rd_entry),
    .count_o(count_o), .ovf_o(overflow_o)
  );

  assign rd_code_o  = rd_entry[O_CODE +: CODE_W];
  assign rd_src_o   = rd_entry[O_SRC +: NSRC];
  assign rd_ts_o    = rd_entry[O_TS +: TS_W];
  assign rd_cur_o   = rd_entry[O_CUR +: CUR_W];
  assign rd_vbus_o  = rd_entry[O_VBUS +: VBUS_W];
  assign rd_temp_o  = rd_entry[O_TEMP +: TEMP_W];
  assign rd_pos_o   = rd_entry[O_POS +: POS_W];
  assign rd_valid_o = rd_entry[O_VAL +: VAL_W];
  assign rd_en_o    = rd_entry[0];

  AST_EMPTY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> (rd_code_o == FC_NONE)); // R1
  AST_DROP_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_drop |=> overflow_o); // R11
endmodule

// File: tb/test_prot_event_logger.sv
`timescale 1ns/1ps
module test_prot_event_logger;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  trig = '0;
  logic [15:0] codes = '0;
  logic [2:0]  rcause = '0;
  logic [15:0] cur = '0;
  logic [11:0] vbus = '0;
  logic [9:0]  temp = '0;
  logic [15:0] pos = '0;
  logic [3:0]  valid = '0;
  logic        en = 1'b0;
  logic        rd = 1'b0;
  logic [3:0]  o_code, o_src, o_valid;
  logic [15:0] o_ts, o_cur, o_pos;
  logic [11:0] o_vbus;
  logic [9:0]  o_temp;
  logic        o_en, o_ovf;
  logic [2:0]  o_cnt;
  logic [15:0] bcyc;
  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcyc <= '0; else bcyc <= bcyc + 16'd1;

  prot_event_logger #(.DEPTH(DEPTH)) i_prot_event_logger (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .trig_code_i(codes),
    .rcause_i(rcause), .snap_cur_i(cur), .snap_vbus_i(vbus),
    .snap_temp_i(temp), .snap_pos_i(pos), .snap_valid_i(valid),
    .snap_en_i(en), .rd_i(rd), .rd_code_o(o_code), .rd_src_o(o_src),
    .rd_ts_o(o_ts), .rd_cur_o(o_cur), .rd_vbus_o(o_vbus),
    .rd_temp_o(o_temp), .rd_pos_o(o_pos), .rd_valid_o(o_valid),
    .rd_en_o(o_en), .count_o(o_cnt), .overflow_o(o_ovf)
  );

  // {mask[3:0], codes {c3,c2,c1,c0}, seed}
  localparam logic [27:0] VEC [6] = '{
    {4'b0001, 16'h0002, 8'h11},
    {4'b0010, 16'h0010, 8'h22},
    {4'b0100, 16'h0300, 8'h35},
    {4'b1000, 16'h5000, 8'h4c},
    {4'b1111, 16'h4612, 8'h5a},
    {4'b1010, 16'h5040, 8'hf3}
  };

  function automatic logic [15:0] f_cur(logic [7:0] b);  return 16'(b * 3 + 1); endfunction
  function automatic logic [11:0] f_vbus(logic [7:0] b); return 12'(b * 5); endfunction
  function automatic logic [9:0]  f_temp(logic [7:0] b); return 10'(b + 7); endfunction
  function automatic logic [15:0] f_pos(logic [7:0] b);  return {4'h0, b, 4'h3}; endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_snap(logic [7:0] b);
    cur = f_cur(b); vbus = f_vbus(b); temp = f_temp(b);
    pos = f_pos(b); valid = b[3:0]; en = b[4];
  endtask

  task automatic wait_cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // compare the oldest record, then pop it
  task automatic rd_chk(logic [3:0] c, logic [3:0] s, logic [15:0] ts, logic [7:0] b);
    chk("R2", "code", o_code, c);
    chk("R3", "source", o_src, s);
    chk("R4", "timestamp", o_ts, ts);
    chk("R5", "current", o_cur, f_cur(b));
    chk("R5", "vbus", o_vbus, f_vbus(b));
    chk("R5", "temp", o_temp, f_temp(b));
    chk("R5", "position", o_pos, f_pos(b));
    chk("R5", "valid", o_valid, b[3:0]);
    chk("R5", "enable", o_en, b[4]);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_reset(logic [2:0] cause);
    rst_n = 1'b0; rcause = cause; trig = '0; rd = 1'b0;
    wait_cyc(3);
  endtask

  initial begin
    #500000;
    nerr++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] ets;
    do_reset(3'b000);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(3);
    // R1 and zero-cause half of R7
    chk("R1", "count", o_cnt, 0);
    chk("R1", "overflow", o_ovf, 0);
    chk("R1", "empty code", o_code, 0);
    chk("R1", "empty ts", o_ts, 0);
    chk("R7", "no record for zero cause", o_cnt, 0);

    // table walk: R2 R3 R4 R5 R6
    foreach (VEC[v]) begin
      trig = VEC[v][27:24]; codes = VEC[v][23:8]; set_snap(VEC[v][7:0]);
      ets = bcyc;
      @(negedge clk);
      trig = '0; set_snap(~VEC[v][7:0]);
      wait_cyc(6);
      chk("R6", "record count", o_cnt, $countones(VEC[v][27:24]));
      for (int j = 0; j < 4; j++)
        if (VEC[v][24+j]) rd_chk(VEC[v][8+4*j +: 4], 4'(1 << j), ets, VEC[v][7:0]);
      chk("R10", "drained count", o_cnt, 0);
      chk("R1", "drained code", o_code, 0);
    end

    // R8 latency
    trig = 4'b0100; codes = 16'h0400; set_snap(8'h66); ets = bcyc;
    @(negedge clk); trig = '0;
    chk("R8", "count one edge after strobe", o_cnt, 0);
    @(negedge clk);
    chk("R8", "count two edges after strobe", o_cnt, 1);
    rd_chk(4'd4, 4'b0100, ets, 8'h66);

    // R10 read when empty
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R10", "empty read count", o_cnt, 0);
    trig = 4'b0001; codes = 16'h0003; set_snap(8'h17); ets = bcyc;
    @(negedge clk); trig = '0; wait_cyc(3);
    chk("R10", "count after empty read", o_cnt, 1);
    rd_chk(4'd3, 4'b0001, ets, 8'h17);
    chk("R11", "overflow still clear", o_ovf, 0);

    // R11 retrigger on a busy slot
    trig = 4'b1111; codes = 16'h4321; set_snap(8'h29); ets = bcyc;
    @(negedge clk);
    trig = 4'b1000; codes = 16'h6000; set_snap(8'h90);
    @(negedge clk); trig = '0; wait_cyc(6);
    chk("R11", "overflow after busy strobe", o_ovf, 1);
    chk("R11", "count after busy strobe", o_cnt, 4);
    for (int j = 0; j < 4; j++) rd_chk(4'(j + 1), 4'(1 << j), ets, 8'h29);
    chk("R12", "overflow after drain", o_ovf, 1);
    wait_cyc(4);
    chk("R12", "overflow held", o_ovf, 1);

    // R9 full overwrite
    do_reset(3'b000);
    chk("R12", "overflow cleared by reset", o_ovf, 0);
    @(negedge clk); rst_n = 1'b1; wait_cyc(2);
    trig = 4'b1111; codes = 16'h4321; set_snap(8'h41); ets = bcyc;
    @(negedge clk); trig = '0; wait_cyc(6);
    chk("R9", "count at depth", o_cnt, DEPTH);
    chk("R9", "no overflow at exact fill", o_ovf, 0);
    trig = 4'b0001; codes = 16'h0006; set_snap(8'h52);
    @(negedge clk); trig = '0; wait_cyc(4);
    chk("R9", "count after overwrite", o_cnt, DEPTH);
    chk("R9", "overflow after overwrite", o_ovf, 1);
    for (int j = 1; j < 4; j++) rd_chk(4'(j + 1), 4'(1 << j), ets, 8'h41);
    rd_chk(4'd6, 4'b0001, ets + 16'd7, 8'h52);
    chk("R9", "count after drain", o_cnt, 0);

    // R7 reset cause with a same-cycle path strobe
    do_reset(3'b110);
    @(negedge clk);
    rst_n = 1'b1; trig = 4'b0010; codes = 16'h0010; set_snap(8'h0e);
    @(negedge clk); trig = '0; set_snap(8'hff); wait_cyc(6);
    chk("R7", "count with cause record", o_cnt, 2);
    rd_chk(4'd7, 4'b0110, 16'd0, 8'h0e);
    rd_chk(4'd1, 4'b0010, 16'd0, 8'h0e);
    wait_cyc(4);
    chk("R7", "cause logged once", o_cnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule